// File: doc/BRIEF.md
# SPI Master Frame Engine

This block runs one serial transfer per accepted word as the master of a four-wire SPI link. A word arrives on a parallel valid/ready input. The engine lowers the active-low frame select and toggles the serial clock once per half bit period. It shifts the word out most significant bit first on the serial data output and collects the same number of bits from the serial data input. When the frame ends it presents the received word for one cycle with a valid strobe.

The bit rate comes from the system clock through a two-stage divider. The first stage is an even prescaler and the second is a rate multiplier. Clock polarity and clock phase are selectable, and so is the word length, from 4 to 16 bits. A loopback switch routes the transmit shifter output into the receive shifter. All configuration inputs are plain levels that are sampled when a frame starts.

Back-pressure rules: `tx_ready` is high only while the engine is idle. A word transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While a frame is in progress, `tx_valid` is ignored and the producer holds its word. The receive side has no ready signal. `rx_valid` is a single-cycle strobe, and the consumer must take `rx_data` in that cycle.

Top module: `spi_frame_master`

## Requirements
- R1: The half bit period H equals (P/2)*(cfg_rate+1) system clocks, where P is the effective prescale value. Frame select stays low for exactly (2N+1)*H clocks, where N is the word length.
- R2: Bit 0 of cfg_presc is treated as zero, so an odd value acts as the even value below it. A resulting value of 0 acts as 2.
- R3: The serial clock rests at cfg_cpol while idle. It keeps that level from the fall of frame select until the first edge, and it returns to that level when frame select rises.
- R4: Every frame has exactly 2N serial clock edges. With cfg_cpha=0, data is captured on odd-numbered edges (1, 3, ...). With cfg_cpha=1, data is captured on even-numbered edges (2, 4, ...). The output bit changes only on non-capture edges.
- R5: cfg_size codes 3 to 15 select N = code+1 (4 to 16 bits). Bits are sent most significant first from the low N bits of tx_data, and the bits above N are ignored.
- R6: rx_data holds the N received bits right-justified, first bit most significant, with upper bits zero. It is valid for one cycle with rx_valid and reads zero at all other times.
- R7: With cfg_loop=1, the receive shifter takes the transmit shifter output and sdi is ignored. The sdo pin still carries the data.
- R8: tx_ready is high only when idle. An accepted word makes busy high and frame select low on the next edge. busy stays high through the rx_valid cycle. tx_valid during a frame starts nothing.
- R9: Size, polarity, phase, loopback, rate and prescale are captured when a word is accepted. Changes during a frame do not alter that frame.
- R10: After reset: frame select is high, busy=0, tx_ready=1, rx_valid=0, rx_data=0, and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 4 | Word length code (N = code+1, codes 3..15) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on first edge of a bit, 1: on second |
| cfg_loop | input | 1 | Internal loopback from transmit to receive shifter |
| cfg_rate | input | 8 | Second-stage divider value (0..255) |
| cfg_presc | input | 8 | Prescale value, bit 0 ignored |
| tx_valid | input | 1 | Word to send is present |
| tx_ready | output | 1 | Engine idle and able to take a word |
| tx_data | input | 16 | Word to send, right-justified |
| rx_valid | output | 1 | One-cycle strobe, received word present |
| rx_data | output | 16 | Received word, right-justified |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low frame select |

## Verification
The embedded properties assume that the configuration inputs are plain levels, which may change at any time. They also assume that codes 0 to 2 are never used on cfg_size, and that sdi changes only between capture edges. The stimulus applies configuration only while idle, except in frames that deliberately perturb it mid-frame. A slave model drives sdi right after each capture edge it observes. The random draws keep the rate and prescale small so that frames stay short. Separate directed frames reach the divider extremes.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_RUN  = 2'd1,
    FM_DONE = 2'd2
  } fm_state_e;
endpackage

// File: rtl/spi_fm_clkdiv.sv
module spi_fm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] pre_half,
  input  logic [DIV_W-1:0] rate,
  output logic             half_stb
);
  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] rcnt_q;
  logic             pre_wrap;
  logic             rate_wrap;

  assign pre_wrap  = (pcnt_q == DIV_W'(pre_half - 1'b1));
  assign rate_wrap = (rcnt_q == rate);
  assign half_stb  = run && pre_wrap && rate_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      rcnt_q <= '0;
    end else if (!run) begin
      pcnt_q <= '0;
      rcnt_q <= '0;
    end else if (pre_wrap) begin
      pcnt_q <= '0;
      rcnt_q <= rate_wrap ? '0 : rcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R1: first stage never passes the halved prescale
  a_r1_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt_q < pre_half));
  // R1: second stage never passes the rate value
  a_r1_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rcnt_q <= rate));
endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int CODE_W = $clog2(DATA_W),
  localparam int LEN_W  = CODE_W + 1,
  localparam int PH_W   = $clog2(2 * DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_loop,
  input  logic [DIV_W-1:0]  cfg_rate,
  input  logic [DIV_W-1:0]  cfg_presc,
  input  logic              half_stb,
  output fm_state_e         state,
  output logic [DIV_W-1:0]  pre_half,
  output logic [DIV_W-1:0]  rate,
  output logic [LEN_W-1:0]  n_bits,
  output logic              loop_en,
  output logic              launch,
  output logic              capture,
  output logic              sclk,
  output logic              sel_n
);
  fm_state_e        state_q;
  logic [PH_W-1:0]  ph_q;
  logic             sclk_q;
  logic             sel_n_q;
  logic             cpol_q;
  logic             cpha_q;
  logic             loop_q;
  logic [LEN_W-1:0] n_q;
  logic [DIV_W-1:0] pre_half_q;
  logic [DIV_W-1:0] rate_q;

  logic [LEN_W-1:0] n_d;
  logic [DIV_W-1:0] presc_even;
  logic [DIV_W-1:0] pre_half_d;
  logic             last_ph;
  logic             edge_go;

  assign n_d        = (cfg_size < CODE_W'(3)) ? LEN_W'(4)
                                              : LEN_W'(cfg_size) + LEN_W'(1);
  assign presc_even = {cfg_presc[DIV_W-1:1], 1'b0};
  assign pre_half_d = (presc_even == '0) ? DIV_W'(1) : (presc_even >> 1);

  assign last_ph = (ph_q == PH_W'({n_q, 1'b0}));
  assign edge_go = (state_q == FM_RUN) && half_stb && !last_ph;
  // edge number is ph_q+1; odd edges capture when phase is 0
  assign capture = edge_go && (~ph_q[0] ^ cpha_q);
  assign launch  = edge_go && !(~ph_q[0] ^ cpha_q) && (ph_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FM_IDLE;
      ph_q       <= '0;
      sclk_q     <= 1'b0;
      sel_n_q    <= 1'b1;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      loop_q     <= 1'b0;
      n_q        <= LEN_W'(4);
      pre_half_q <= DIV_W'(1);
      rate_q     <= '0;
    end else begin
      unique case (state_q)
        FM_IDLE: begin
          sclk_q <= cfg_cpol;
          if (start) begin
            state_q    <= FM_RUN;
            sel_n_q    <= 1'b0;
            ph_q       <= '0;
            cpol_q     <= cfg_cpol;
            cpha_q     <= cfg_cpha;
            loop_q     <= cfg_loop;
            n_q        <= n_d;
            pre_half_q <= pre_half_d;
            rate_q     <= cfg_rate;
          end
        end
        FM_RUN: begin
          if (half_stb) begin
            if (last_ph) begin
              state_q <= FM_DONE;
              sel_n_q <= 1'b1;
            end else begin
              ph_q   <= ph_q + 1'b1;
              sclk_q <= ~sclk_q;
            end
          end
        end
        default: state_q <= FM_IDLE;
      endcase
    end
  end

  assign state    = state_q;
  assign pre_half = pre_half_q;
  assign rate     = rate_q;
  assign n_bits   = n_q;
  assign loop_en  = loop_q;
  assign sclk     = sclk_q;
  assign sel_n    = sel_n_q;

  // R3: serial clock moves only on a divider strobe
  a_r3_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FM_RUN && !half_stb) |=> $stable(sclk_q));
  // R3: clock is back at its idle level when the frame closes
  a_r3_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FM_DONE) |-> (sclk_q == cpol_q));
  // R4: phase counter never exceeds twice the word length
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FM_IDLE) |-> (ph_q <= PH_W'({n_q, 1'b0})));
  // R8: frame select low only in the running state
  a_r8_select_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n_q |-> (state_q == FM_RUN));
  // R9: captured settings hold across the frame
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FM_RUN) |=> ($stable(n_q) && $stable(cpha_q) && $stable(rate_q)
                            && $stable(pre_half_q) && $stable(loop_q)));
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  n_bits,
  input  logic [LEN_W-1:0]  n_load,
  input  logic              launch,
  input  logic              capture,
  input  logic              loop_en,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [LEN_W-1:0]  shamt;
  logic              din;

  assign shamt = LEN_W'(DATA_W) - n_load;
  assign sdo   = tx_sh_q[DATA_W-1];
  assign din   = loop_en ? sdo : sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (load) begin
      tx_sh_q <= tx_word << shamt;
      rx_sh_q <= '0;
    end else begin
      if (launch)  tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      if (capture) rx_sh_q <= {rx_sh_q[DATA_W-2:0], din};
    end
  end

  assign rx_word = rx_sh_q;

  // R6: received bits never climb above the word length
  a_r6_rx_justified: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sh_q >> n_bits) == '0);
  // R4: shifting out and sampling in never share an edge
  a_r4_edge_roles: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> $stable(tx_sh_q));
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int CODE_W = $clog2(DATA_W),
  localparam int LEN_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_loop,
  input  logic [DIV_W-1:0]  cfg_rate,
  input  logic [DIV_W-1:0]  cfg_presc,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              sel_n
);
  fm_state_e         state;
  logic [DIV_W-1:0]  pre_half;
  logic [DIV_W-1:0]  rate;
  logic [LEN_W-1:0]  n_bits;
  logic [LEN_W-1:0]  n_load;
  logic              loop_en;
  logic              launch;
  logic              capture;
  logic              half_stb;
  logic              accept;
  logic              run;
  logic [DATA_W-1:0] rx_word;

  assign tx_ready = (state == FM_IDLE);
  assign accept   = tx_valid && tx_ready;
  assign run      = (state == FM_RUN);
  assign busy     = (state != FM_IDLE);
  assign rx_valid = (state == FM_DONE);
  assign rx_data  = rx_valid ? rx_word : '0;
  assign n_load   = (cfg_size < CODE_W'(3)) ? LEN_W'(4)
                                            : LEN_W'(cfg_size) + LEN_W'(1);

  spi_fm_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .cfg_size (cfg_size),
    .cfg_cpol (cfg_cpol),
    .cfg_cpha (cfg_cpha),
    .cfg_loop (cfg_loop),
    .cfg_rate (cfg_rate),
    .cfg_presc(cfg_presc),
    .half_stb (half_stb),
    .state    (state),
    .pre_half (pre_half),
    .rate     (rate),
    .n_bits   (n_bits),
    .loop_en  (loop_en),
    .launch   (launch),
    .capture  (capture),
    .sclk     (sclk),
    .sel_n    (sel_n)
  );

  spi_fm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pre_half(pre_half),
    .rate    (rate),
    .half_stb(half_stb)
  );

  spi_fm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .tx_word(tx_data),
    .n_bits (n_bits),
    .n_load (n_load),
    .launch (launch),
    .capture(capture),
    .loop_en(loop_en),
    .sdi    (sdi),
    .sdo    (sdo),
    .rx_word(rx_word)
  );

  // R8: an accepted word opens a frame on the next edge
  a_r8_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !sel_n));
  // R6: the result strobe follows the close of frame select, for one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (sel_n && $past(!sel_n)) ##1 !rx_valid);
endmodule

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_size = 4'd7;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loop = 1'b0;
  logic [7:0]  cfg_rate = 8'd0, cfg_presc = 8'd2;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        sdi = 1'b0;
  logic        tx_ready, rx_valid, busy, sclk, sdo, sel_n;
  logic [15:0] rx_data;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  int          exp_n = 8;
  bit          exp_cpol = 0, exp_cpha = 0;
  logic [15:0] slv_word = 16'h0;
  bit          prev_sel = 1, prev_sclk = 0, m_first_ok = 0;
  int          m_edges = 0, m_caps = 0, m_low = 0;
  logic [15:0] m_word = 16'h0;

  spi_frame_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_loop(cfg_loop), .cfg_rate(cfg_rate),
    .cfg_presc(cfg_presc), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .sel_n(sel_n)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // slave model: observes the serial pins, drives sdi after capture edges
  always @(negedge clk) begin
    if (!sel_n) begin
      if (prev_sel) begin
        m_edges = 0; m_caps = 0; m_word = 16'h0; m_low = 0;
        m_first_ok = (sclk === exp_cpol);
        sdi = slv_word[exp_n-1];
      end
      m_low++;
      if (sclk !== prev_sclk) begin
        m_edges++;
        if (m_edges[0] ^ exp_cpha) begin
          m_word = {m_word[14:0], sdo};
          m_caps++;
          if (m_caps < exp_n) sdi = slv_word[exp_n-1-m_caps];
        end
      end
    end
    prev_sclk = sclk;
    prev_sel  = sel_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_len(input int rate, input int presc);
    int pe = presc & 254;
    if (pe == 0) pe = 2;
    return (pe / 2) * (rate + 1);
  endfunction

  task automatic run_frame(input int code, input bit cpol, input bit cpha,
                           input bit loop, input int rate, input int presc,
                           input logic [15:0] txw, input logic [15:0] slw,
                           input bit perturb);
    int n = code + 1;
    logic [15:0] mask = 16'((32'd1 << n) - 1);
    logic [15:0] exp_rx = loop ? (txw & mask) : (slw & mask);
    int exp_low = (2 * n + 1) * half_len(rate, presc);
    int wait_cnt = 0;
    @(negedge clk);
    cfg_size = 4'(code); cfg_cpol = cpol; cfg_cpha = cpha; cfg_loop = loop;
    cfg_rate = 8'(rate); cfg_presc = 8'(presc);
    exp_n = n; exp_cpol = cpol; exp_cpha = cpha; slv_word = slw;
    repeat (3) @(negedge clk);
    check(sclk === cpol, "R3", "idle clock level", sclk, cpol);
    check(tx_ready === 1'b1, "R8", "ready while idle", tx_ready, 1);
    tx_valid = 1'b1; tx_data = txw;
    @(negedge clk);
    tx_valid = 1'b0;
    check(busy === 1'b1 && tx_ready === 1'b0 && sel_n === 1'b0, "R8",
          "busy after accept", {busy, tx_ready, sel_n}, 3'b100);
    if (perturb) begin
      repeat (2) @(negedge clk);
      cfg_size = 4'(3 + $urandom % 13); cfg_cpol = ~cpol; cfg_cpha = ~cpha;
      cfg_loop = ~loop; cfg_rate = 8'(rate + 3); cfg_presc = 8'(presc + 6);
      tx_valid = 1'b1; tx_data = ~txw;  // R8: ignored while busy
    end
    while (rx_valid !== 1'b1 && wait_cnt < 20000) begin
      @(negedge clk);
      wait_cnt++;
    end
    tx_valid = 1'b0;
    check(rx_valid === 1'b1, "R8", "frame completes", rx_valid, 1);
    check(rx_data === exp_rx, loop ? "R7" : "R6", "received word", rx_data, exp_rx);
    check(m_word === (txw & mask), "R5", "serial output word", m_word, txw & mask);
    check(m_edges == 2 * n, "R4", "edge count", m_edges, 2 * n);
    check(m_caps == n, "R4", "capture count", m_caps, n);
    check(m_low == exp_low, perturb ? "R9" : "R1", "select low cycles", m_low, exp_low);
    check(m_first_ok, "R3", "clock idle at select fall", m_first_ok, 1);
    check(sclk === cpol && sel_n === 1'b1 && busy === 1'b1, "R3",
          "clock rest at frame end", {sclk, sel_n, busy}, {cpol, 2'b11});
    @(negedge clk);
    check(busy === 1'b0 && tx_ready === 1'b1 && sel_n === 1'b1 && rx_valid === 1'b0
          && rx_data === 16'h0, "R8", "return to idle", {busy, tx_ready, sel_n, rx_valid}, 4'b0110);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(sel_n === 1'b1 && busy === 1'b0 && tx_ready === 1'b1 && rx_valid === 1'b0,
          "R10", "reset outputs", {sel_n, busy, tx_ready, rx_valid}, 4'b1010);
    check(rx_data === 16'h0 && sclk === 1'b0, "R10", "reset data and clock",
          {rx_data, sclk}, 0);
    rst_n = 1'b1;
    // four clock modes, 8 bits
    run_frame(7, 0, 0, 0, 0, 2, 16'h00A5, 16'h003C, 0);
    run_frame(7, 0, 1, 0, 1, 4, 16'h005A, 16'h00C3, 0);
    run_frame(7, 1, 0, 0, 0, 2, 16'h0081, 16'h007E, 0);
    run_frame(7, 1, 1, 0, 2, 2, 16'h00F0, 16'h000F, 0);
    // R5: shortest and longest words, upper bits ignored
    run_frame(3, 0, 0, 0, 0, 2, 16'hFFF5, 16'h000A, 0);
    run_frame(15, 1, 0, 0, 0, 2, 16'hA5C3, 16'h3C5A, 0);
    // R2: odd prescale and zero prescale
    run_frame(7, 0, 0, 0, 2, 5, 16'h0033, 16'h00CC, 0);
    run_frame(5, 1, 1, 0, 1, 0, 16'h002D, 16'h0012, 0);
    // R1: divider extremes
    run_frame(3, 0, 1, 0, 255, 2, 16'h0009, 16'h0006, 0);
    run_frame(3, 1, 0, 0, 0, 254, 16'h0006, 16'h0009, 0);
    // R7: loopback in both phases, sdi carries other data
    run_frame(11, 0, 1, 1, 0, 2, 16'h0ABC, 16'h0543, 0);
    run_frame(9, 1, 0, 1, 1, 2, 16'h0155, 16'h02AA, 0);
    // R9: settings changed mid-frame
    run_frame(7, 0, 0, 0, 1, 2, 16'h0096, 16'h0069, 1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      run_frame(3 + $urandom % 13, $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 4, $urandom % 9, 16'($urandom), 16'($urandom),
                ($urandom % 4) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule